// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block holds four pulse-width modulation channels behind a small register interface. A single write strobe, a byte address and a 32-bit data word load the registers on a rising clock edge. The read data is a combinational decode of the same address. A shared control word holds a run bit, a polarity bit and a drive-type bit for each channel. Each channel also has a 16-bit period count and a 16-bit duty count. A shared prescale word holds one 6-bit divider field per channel.

A running channel advances its period counter once every (prescale+1) clocks. The output is in its active phase while the counter is below the duty count. A period or duty change becomes visible only at the next period boundary, so a pulse is never cut short or stretched.

When a channel is stopped, its counters are held cleared and its output sits at the inactive level. Once a channel stops, it cannot run again until a guard interval of `OFF_HOLD` clocks has passed. After that it restarts at the beginning of a period.

Top module: `quad_pwm`

## Requirements
- R1: The register map uses these byte addresses: control at 0x00, channel n period at 0x04+8n, channel n duty at 0x08+8n, prescale at 0x24. Each register reads back the last value written, with unused bits reading zero. The period and duty registers keep bits 15:0, and any other address reads 0. After reset every register reads 0.
- R2: In the control word, bit n is the run bit of channel n, bit 8+n is its polarity and bit 15+n is its drive type. All other control bits read zero.
- R3: The 6-bit prescale field of channel n occupies bits (3-n)*6+5 down to (3-n)*6. Channel 0 is therefore at bits 23:18 and channel 3 at bits 5:0. Bits 31:24 read zero.
- R4: A running channel repeats a period of (prescale+1)×period clocks. It is active for the first (prescale+1)×duty clocks of each period.
- R5: A duty count of 0 keeps the output inactive. A duty count equal to or above the period count keeps it active for the whole period, and this includes period counts of 0 and 1.
- R6: With polarity 1, the output is high while active. With polarity 0, it is low while active. A stopped channel drives the inactive level, which is the inverse of its polarity bit.
- R7: With drive type 0, the output enable of the channel is always 1. With drive type 1, the output enable is 1 only during the active phase.
- R8: Writes to period, duty or prescale while a channel runs do not alter the period in progress. The new values apply from the next period boundary.
- R9: Clearing a run bit stops the channel at the next clock. The channel cannot run again until OFF_HOLD clocks have passed, even if the run bit is set again at once. It then starts at the beginning of a period, in the active phase when duty is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and counters |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational decode of bus_addr |
| pwm_out | output | 4 | Output level of each channel |
| pwm_oe | output | 4 | Output enable of each channel |

## Verification
Each channel's state is visible at its pins on every clock. A wrong prescale tick, counter wrap or latch of the shadow copies therefore shows on the first clock where the active phase starts or ends at the wrong time. A missed boundary latch shows as a wrong pulse width within one period of a register write. A wrong guard counter shows as an output that starts early or late after a stop-then-run sequence. The bench compares both pins of all four channels on every clock with a behavioural model, so an internal error is reported on the cycle it first reaches a port.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

    localparam int NCH        = 4;
    localparam int CW         = 16;
    localparam int PSW        = 6;
    localparam int DW         = 32;
    localparam int AW         = 6;

    localparam int RUN_LSB    = 0;
    localparam int POL_LSB    = 8;
    localparam int TYPE_LSB   = 15;

    localparam int CTRL_ADDR  = 'h00;
    localparam int PER_BASE   = 'h04;
    localparam int DUTY_BASE  = 'h08;
    localparam int CH_STRIDE  = 8;
    localparam int PS_ADDR    = 'h24;

    localparam int PSWORD_W   = NCH * PSW;

    typedef struct packed {
        logic [DW-1:0]           ctrl;
        logic [NCH-1:0][CW-1:0]  per;
        logic [NCH-1:0][CW-1:0]  duty;
        logic [PSWORD_W-1:0]     ps;
    } regfile_t;

    function automatic logic [DW-1:0] ctrl_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NCH; i++) begin
            m[RUN_LSB + i]  = 1'b1;
            m[POL_LSB + i]  = 1'b1;
            m[TYPE_LSB + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
    import quad_pwm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [DW-1:0]            ctrl_word,
    output logic [NCH-1:0][CW-1:0]   per_vec,
    output logic [NCH-1:0][CW-1:0]   duty_vec,
    output logic [PSWORD_W-1:0]      ps_word
);

    localparam logic [DW-1:0] CMASK = ctrl_mask();

    regfile_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (bus_addr == AW'(CTRL_ADDR))
                r_d.ctrl = bus_wdata & CMASK;
            if (bus_addr == AW'(PS_ADDR))
                r_d.ps = bus_wdata[PSWORD_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(PER_BASE + CH_STRIDE * i))
                    r_d.per[i] = bus_wdata[CW-1:0];
                if (bus_addr == AW'(DUTY_BASE + CH_STRIDE * i))
                    r_d.duty[i] = bus_wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(CTRL_ADDR))
            bus_rdata = r_q.ctrl;
        if (bus_addr == AW'(PS_ADDR))
            bus_rdata = DW'(r_q.ps);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(PER_BASE + CH_STRIDE * i))
                bus_rdata = DW'(r_q.per[i]);
            if (bus_addr == AW'(DUTY_BASE + CH_STRIDE * i))
                bus_rdata = DW'(r_q.duty[i]);
        end
    end

    assign ctrl_word = r_q.ctrl;
    assign per_vec   = r_q.per;
    assign duty_vec  = r_q.duty;
    assign ps_word   = r_q.ps;

endmodule

// File: rtl/quad_pwm_chan.sv
module quad_pwm_chan
    import quad_pwm_pkg::*;
#(
    parameter int OFF_HOLD = 50,
    localparam int HW = $clog2(OFF_HOLD + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_req,
    input  logic            pol,
    input  logic            otype,
    input  logic [CW-1:0]   per,
    input  logic [CW-1:0]   duty,
    input  logic [PSW-1:0]  ps,
    output logic            pwm_out,
    output logic            pwm_oe,
    output logic            running
);

    typedef struct packed {
        logic            run;
        logic [HW-1:0]   hold;
        logic [PSW-1:0]  pre;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   per_l;
        logic [CW-1:0]   duty_l;
        logic [PSW-1:0]  ps_l;
    } chan_t;

    chan_t s_d, s_q;
    logic [CW:0] cnt_inc;
    logic        active;

    assign cnt_inc = {1'b0, s_q.cnt} + 1'b1;

    always_comb begin
        s_d     = s_q;
        s_d.run = run_req && (s_q.hold == '0);

        if (s_q.run && !run_req)
            s_d.hold = HW'(OFF_HOLD);
        else if (s_q.hold != '0)
            s_d.hold = s_q.hold - 1'b1;

        if (!s_q.run) begin
            s_d.pre    = '0;
            s_d.cnt    = '0;
            s_d.per_l  = per;
            s_d.duty_l = duty;
            s_d.ps_l   = ps;
        end else if (s_q.pre == s_q.ps_l) begin
            s_d.pre = '0;
            if (cnt_inc >= {1'b0, s_q.per_l}) begin
                s_d.cnt    = '0;
                s_d.per_l  = per;
                s_d.duty_l = duty;
                s_d.ps_l   = ps;
            end else begin
                s_d.cnt = cnt_inc[CW-1:0];
            end
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.run && (s_q.cnt < s_q.duty_l);
    assign pwm_out = pol ? active : !active;
    assign pwm_oe  = otype ? active : 1'b1;
    assign running = s_q.run;

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
    import quad_pwm_pkg::*;
#(
    parameter int OFF_HOLD = 50
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [5:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [3:0]     pwm_out,
    output logic [3:0]     pwm_oe
);

    logic [DW-1:0]           ctrl_word;
    logic [NCH-1:0][CW-1:0]  per_vec;
    logic [NCH-1:0][CW-1:0]  duty_vec;
    logic [PSWORD_W-1:0]     ps_word;
    logic [NCH-1:0]          ch_run;
    logic [NCH-1:0]          ch_pol;
    logic [NCH-1:0]          ch_type;

    quad_pwm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_word (ctrl_word),
        .per_vec   (per_vec),
        .duty_vec  (duty_vec),
        .ps_word   (ps_word)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_pol[g]  = ctrl_word[POL_LSB + g];
        assign ch_type[g] = ctrl_word[TYPE_LSB + g];

        quad_pwm_chan #(.OFF_HOLD(OFF_HOLD)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_req (ctrl_word[RUN_LSB + g]),
            .pol     (ch_pol[g]),
            .otype   (ch_type[g]),
            .per     (per_vec[g]),
            .duty    (duty_vec[g]),
            .ps      (ps_word[(NCH-1-g)*PSW +: PSW]),
            .pwm_out (pwm_out[g]),
            .pwm_oe  (pwm_oe[g]),
            .running (ch_run[g])
        );
    end

endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk #(
    parameter int NCH = 4
)(
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [5:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    ctrl_q,
    input logic [NCH-1:0] pol,
    input logic [NCH-1:0] otype,
    input logic [NCH-1:0] run,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] pwm_oe
);

    localparam logic [31:0] CMASK = quad_pwm_pkg::ctrl_mask();

    // R2: the control word keeps only the defined bits of the last write
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h00) |=> (ctrl_q == ($past(bus_wdata) & CMASK)));

    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R7: full drive keeps the enable asserted
        a_r7_full_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !otype[g] |-> pwm_oe[g]);
        // R7: open-drain enable only at the active level
        a_r7_od_level: assert property (@(posedge clk) disable iff (!rst_n)
            (otype[g] && pwm_oe[g]) |-> (pwm_out[g] == pol[g]));
        // R6: stopped channel sits at the inactive level
        a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |-> (pwm_out[g] == !pol[g]));
        // R9: a stop is never followed by an immediate restart
        a_r9_off_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run[g]) |=> !run[g]);
    end

endmodule

bind quad_pwm quad_pwm_chk #(.NCH(quad_pwm_pkg::NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_word),
    .pol       (ch_pol),
    .otype     (ch_type),
    .run       (ch_run),
    .pwm_out   (pwm_out),
    .pwm_oe    (pwm_oe)
);

// File: tb/quad_pwm_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_tb_top;

    localparam int HOLD = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  pwm_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R6";

    always #4 clk = ~clk;

    quad_pwm #(.OFF_HOLD(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    // behavioural reference
    int m_ctrl, m_ps;
    int m_per[4], m_dut[4];
    int c_run[4], c_hold[4], c_pre[4], c_cnt[4], c_per[4], c_dut[4], c_ps[4];

    function automatic int ps_of(int word, int ch);
        return (word >> ((3 - ch) * 6)) & 63;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_ps = 0;
            for (int i = 0; i < 4; i++) begin
                m_per[i] = 0; m_dut[i] = 0;
                c_run[i] = 0; c_hold[i] = 0; c_pre[i] = 0; c_cnt[i] = 0;
                c_per[i] = 0; c_dut[i] = 0; c_ps[i] = 0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                int en, nrun;
                en   = (m_ctrl >> i) & 1;
                nrun = (en != 0 && c_hold[i] == 0) ? 1 : 0;
                if (c_run[i] != 0 && en == 0) c_hold[i] = HOLD;
                else if (c_hold[i] > 0)        c_hold[i] = c_hold[i] - 1;
                if (c_run[i] == 0) begin
                    c_pre[i] = 0; c_cnt[i] = 0;
                    c_per[i] = m_per[i]; c_dut[i] = m_dut[i]; c_ps[i] = ps_of(m_ps, i);
                end else if (c_pre[i] == c_ps[i]) begin
                    c_pre[i] = 0;
                    if (c_cnt[i] + 1 >= c_per[i]) begin
                        c_cnt[i] = 0;
                        c_per[i] = m_per[i]; c_dut[i] = m_dut[i]; c_ps[i] = ps_of(m_ps, i);
                    end else c_cnt[i] = c_cnt[i] + 1;
                end else c_pre[i] = c_pre[i] + 1;
                c_run[i] = nrun;
            end
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_ctrl = int'(bus_wdata & 32'h0007_8F0F);
                    6'h24: m_ps   = int'(bus_wdata & 32'h00FF_FFFF);
                    default: begin
                        for (int i = 0; i < 4; i++) begin
                            if (bus_addr == 6'(4 + 8 * i)) m_per[i] = int'(bus_wdata[15:0]);
                            if (bus_addr == 6'(8 + 8 * i)) m_dut[i] = int'(bus_wdata[15:0]);
                        end
                    end
                endcase
            end
        end
    end

    // per-clock comparison (R4, R6, R7 plus the phase under test)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < 4; i++) begin
                bit act, pol, typ, eo, ee;
                act = (c_run[i] != 0) && (c_cnt[i] < c_dut[i]);
                pol = ((m_ctrl >> (8 + i)) & 1) != 0;
                typ = ((m_ctrl >> (15 + i)) & 1) != 0;
                eo  = pol ? act : !act;
                ee  = typ ? act : 1'b1;
                checks++;
                if (pwm_out[i] !== eo) begin
                    errors++;
                    $display("FAIL %s pwm_out[%0d] actual %b expected %b at %0t", cur_req, i, pwm_out[i], eo, $time);
                end
                checks++;
                if (pwm_oe[i] !== ee) begin
                    errors++;
                    $display("FAIL R7 pwm_oe[%0d] actual %b expected %b at %0t", i, pwm_oe[i], ee, $time);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int ch, input int n, input bit pol,
                           output int act, output int oec);
        act = 0; oec = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch] == pol) act++;
            if (pwm_oe[ch]) oec++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a, o, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R1, R6, R7)
        rd_check("R1", 6'h00, 32'h0);
        rd_check("R1", 6'h24, 32'h0);
        rd_check("R1", 6'h14, 32'h0);
        check("R6", int'(pwm_out), 15);
        check("R7", int'(pwm_oe), 15);

        // read-back masking (R1, R2, R3)
        cur_req = "R1";
        wr(6'h00, 32'hFFFF_FFFF);
        rd_check("R2", 6'h00, 32'h0007_8F0F);
        wr(6'h24, 32'hFFFF_FFFF);
        rd_check("R3", 6'h24, 32'h00FF_FFFF);
        wr(6'h14, 32'hABCD_1234);
        rd_check("R1", 6'h14, 32'h0000_1234);
        wr(6'h20, 32'h5555_9876);
        rd_check("R1", 6'h20, 32'h0000_9876);
        rd_check("R1", 6'h28, 32'h0);
        wr(6'h00, 32'h0);
        wr(6'h24, 32'h0);
        idle(HOLD + 10);

        // basic waveform ch0 (R4)
        cur_req = "R4";
        wr(6'h04, 10); wr(6'h08, 3);
        wr(6'h00, 32'h0000_0101);
        idle(5);
        measure(0, 100, 1'b1, a, o);
        check("R4", a, 30);

        // ch1 prescale 2 in bits 17:12, inverted polarity (R3, R6)
        cur_req = "R3";
        wr(6'h24, 32'h0000_2000);
        wr(6'h0C, 4); wr(6'h10, 1);
        wr(6'h00, 32'h0000_0103);
        idle(5);
        measure(1, 120, 1'b0, a, o);
        check("R3", a, 30);
        check("R6", o, 120);

        // duty 0 and duty above period (R5)
        cur_req = "R5";
        wr(6'h14, 8); wr(6'h18, 0);
        wr(6'h1C, 5); wr(6'h20, 20);
        wr(6'h00, 32'h0000_0D0F);
        idle(5);
        measure(2, 50, 1'b1, a, o);
        check("R5", a, 0);
        measure(3, 50, 1'b1, a, o);
        check("R5", a, 50);
        wr(6'h14, 1); wr(6'h18, 1);
        idle(12);
        measure(2, 40, 1'b1, a, o);
        check("R5", a, 40);

        // open-drain enable (R7)
        cur_req = "R7";
        wr(6'h20, 2);
        wr(6'h00, 32'h0004_0D0F);
        idle(10);
        measure(3, 50, 1'b1, a, o);
        check("R7", a, 20);
        check("R7", o, 20);

        // boundary-aligned update (R8)
        cur_req = "R8";
        n = 0;
        while (pwm_out[0] != 1'b0 && n < 50) begin @(negedge clk); n++; end
        while (pwm_out[0] != 1'b1 && n < 100) begin @(negedge clk); n++; end
        idle(4);
        wr(6'h08, 7);
        measure(0, 5, 1'b1, a, o);
        check("R8", a, 0);
        idle(20);
        measure(0, 100, 1'b1, a, o);
        check("R8", a, 70);

        // stop then immediate run (R9)
        cur_req = "R9";
        wr(6'h00, 32'h0004_0D0E);
        wr(6'h00, 32'h0004_0D0F);
        n = 0;
        while (pwm_out[0] != 1'b1 && n < 200) begin @(negedge clk); n++; end
        check("R9", n, HOLD + 1);
        n = 0;
        while (pwm_out[0] == 1'b1 && n < 50) begin @(negedge clk); n++; end
        check("R9", n, 7);

        idle(20);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule